// File: doc/BRIEF.md
# Header-and-payload streaming packet framer

The framer turns one transaction into one packet on a 128-bit ready/valid transmit stream. A command port hands it an opaque 10-byte header together with a payload length in bytes. The payload then arrives as big-endian 32-bit words on a separate ready/valid port. The framer places the header and payload back to back in 16-byte beats. The earliest byte of the packet goes in the most significant lane. Each beat carries start and end markers, a count of unused trailing lanes on the final beat, and the total packet length in bytes.

Only one packet is in flight at a time. A new command is taken only while the framer is idle. A command whose total length would not fit the 9-bit size field is refused with a one-cycle error pulse and produces no output. When the payload source stalls, output valid drops until enough bytes are buffered for the next beat, or for the final, shorter beat. Beat contents and markers do not change because of the stall.

Top module: `pkt_framer`

## Requirements
- R1: A beat is transferred only in a cycle with tx_valid_o and tx_ready_i both high. While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o, tx_sop_o, tx_eop_o, tx_empty_o and tx_size_o hold their values.
- R2: Packet byte n goes in lane n mod 16 of beat n div 16. Lane k of a beat is tx_data_o[127-8k -: 8], so lane 0 is bits 127:120. Header byte 0 is cmd_hdr_i[79:72] and header byte 9 is cmd_hdr_i[7:0]. Payload byte 0 follows header byte 9 directly, in lane 10 of the first beat.
- R3: tx_sop_o is high on the first beat of a packet only. tx_eop_o is high on the last beat only. A one-beat packet has both high.
- R4: tx_size_o equals 10 plus cmd_len_i, the total packet length in bytes. It is presented with the first beat and held for the rest of the packet.
- R5: A packet of S bytes takes ceil(S/16) beats. tx_empty_o is 0 on every beat except the last. On the last beat it is 16*ceil(S/16) minus S, which is 0 when S is a multiple of 16.
- R6: Lanes beyond the end of the packet on the final beat are driven to zero.
- R7: cmd_ready_o is high exactly when the framer is idle. After a command with a legal length is accepted, cmd_ready_o is low until the last beat of that packet has been formed.
- R8: A command accepted with cmd_len_i above 501 produces cmd_err_o high for exactly the next cycle. It produces no beat and pulls no payload, and cmd_ready_o stays high.
- R9: Payload words are big-endian: bits 31:24 hold the earliest byte. Exactly ceil(cmd_len_i/4) words are taken per packet. The padding bytes of a final partial word are discarded.
- R10: If payload words are held back mid-packet, tx_valid_o drops between beats. The beats still follow R2 to R6 exactly.
- R11: pl_ready_o is low whenever the framer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Framer idle, command taken this cycle |
| cmd_hdr_i | input | 80 | Opaque header, byte 0 in bits 79:72 |
| cmd_len_i | input | 9 | Payload length in bytes |
| cmd_err_o | output | 1 | One-cycle pulse: command refused, length too large |
| pl_valid_i | input | 1 | Payload word present |
| pl_ready_o | output | 1 | Payload word taken this cycle |
| pl_data_i | input | 32 | Big-endian payload word |
| tx_valid_o | output | 1 | Beat present |
| tx_ready_i | input | 1 | Sink takes the beat |
| tx_data_o | output | 128 | Beat data, lane 0 in bits 127:120 |
| tx_sop_o | output | 1 | First beat of packet |
| tx_eop_o | output | 1 | Last beat of packet |
| tx_empty_o | output | 4 | Unused trailing lanes on the last beat |
| tx_size_o | output | 9 | Total packet length in bytes |

## Verification
The assertions assume the sink's ready is free to toggle, while the payload source sends only words that belong to a command already given, in order. They also assume reset is held for at least one edge before traffic starts. The stimulus keeps within this: the bench queues exactly ceil(len/4) words per accepted legal command, and queues none for a refused one. It holds each payload word until it is taken and asserts the command only through a task that waits for the handshake. Ready and payload gaps are varied per phase, from steady flow to long stalls, so the hold-stable and stall properties see both quiet and busy inputs.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int LANE_W = 8;
  typedef enum logic {PF_IDLE, PF_BUSY} pf_state_e;
endpackage

// File: rtl/pf_byte_acc.sv
module pf_byte_acc #(
  parameter int BEAT_B = 16,
  parameter int WORD_B = 4,
  parameter int HDR_B  = 10,
  localparam int ACC_B = BEAT_B + WORD_B,
  localparam int CNT_W = $clog2(ACC_B + 1),
  localparam int NB_W  = $clog2(BEAT_B + 1),
  localparam int WN_W  = $clog2(WORD_B + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [HDR_B*8-1:0]    hdr_i,
  input  logic                  wr_i,
  input  logic [WORD_B*8-1:0]   wr_word_i,
  input  logic [WN_W-1:0]       wr_n_i,
  input  logic                  pop_i,
  input  logic [NB_W-1:0]       pop_n_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [CNT_W-1:0]      mid_cnt_o,
  output logic [BEAT_B*8-1:0]   head_o
);
  localparam int IDX_W = $clog2(ACC_B);

  logic [ACC_B-1:0][7:0] acc_q, acc_mid, acc_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;

  // append the valid bytes of an incoming word behind the stored ones
  always_comb begin
    acc_mid   = acc_q;
    mid_cnt_o = cnt_q;
    if (wr_i) begin
      for (int k = 0; k < WORD_B; k++) begin
        if (k < int'(wr_n_i) && int'(cnt_q) + k < ACC_B)
          acc_mid[IDX_W'(int'(cnt_q) + k)] = wr_word_i[(WORD_B-1-k)*8 +: 8];
      end
      mid_cnt_o = cnt_q + CNT_W'(wr_n_i);
    end
  end

  always_comb begin
    for (int k = 0; k < BEAT_B; k++)
      head_o[(BEAT_B-1-k)*8 +: 8] = acc_mid[IDX_W'(k)];
  end

  always_comb begin
    acc_d = acc_mid;
    cnt_d = mid_cnt_o;
    if (load_i) begin
      acc_d = '0;
      for (int k = 0; k < HDR_B; k++)
        acc_d[IDX_W'(k)] = hdr_i[(HDR_B-1-k)*8 +: 8];
      cnt_d = CNT_W'(HDR_B);
    end else if (pop_i) begin
      for (int i = 0; i < ACC_B; i++) begin
        if (i + int'(pop_n_i) < ACC_B) acc_d[IDX_W'(i)] = acc_mid[IDX_W'(i + int'(pop_n_i))];
        else                           acc_d[IDX_W'(i)] = '0;
      end
      cnt_d = mid_cnt_o - CNT_W'(pop_n_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R9: an appended word never spills past the buffer
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (int'(cnt_q) + int'(wr_n_i) <= ACC_B));
endmodule

// File: rtl/pf_beat_out.sv
module pf_beat_out #(
  parameter int BEAT_B = 16,
  parameter int SIZE_W = 9,
  localparam int NB_W  = $clog2(BEAT_B + 1),
  localparam int EMP_W = $clog2(BEAT_B)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [BEAT_B*8-1:0]  head_i,
  input  logic [NB_W-1:0]      take_n_i,
  input  logic                 sop_i,
  input  logic                 eop_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  logic                 ready_i,
  output logic                 slot_free_o,
  output logic                 valid_o,
  output logic [BEAT_B*8-1:0]  data_o,
  output logic                 sop_o,
  output logic                 eop_o,
  output logic [EMP_W-1:0]     empty_o,
  output logic [SIZE_W-1:0]    size_o
);
  logic [BEAT_B*8-1:0] masked;

  always_comb begin
    for (int k = 0; k < BEAT_B; k++)
      masked[(BEAT_B-1-k)*8 +: 8] = (k < int'(take_n_i)) ? head_i[(BEAT_B-1-k)*8 +: 8] : 8'h00;
  end

  assign slot_free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      empty_o <= '0;
      size_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= masked;
      sop_o   <= sop_i;
      eop_o   <= eop_i;
      empty_o <= eop_i ? EMP_W'(BEAT_B - int'(take_n_i)) : '0;
      size_o  <= size_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R1: a stalled beat is held unchanged
  a_r1_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(sop_o) &&
                               $stable(eop_o) && $stable(empty_o) && $stable(size_o)));
  // R5: only the closing beat may report empty lanes
  a_r5_empty_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !eop_o) |-> (empty_o == '0));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pf_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int WORD_W = 32,
  parameter int HDR_B  = 10,
  parameter int SIZE_W = 9,
  localparam int BEAT_B  = DATA_W / LANE_W,
  localparam int WORD_B  = WORD_W / LANE_W,
  localparam int EMP_W   = $clog2(BEAT_B),
  localparam int MAX_TOT = (1 << SIZE_W) - 1,
  localparam int MAX_PL  = MAX_TOT - HDR_B
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic [HDR_B*8-1:0]    cmd_hdr_i,
  input  logic [SIZE_W-1:0]     cmd_len_i,
  output logic                  cmd_err_o,
  input  logic                  pl_valid_i,
  output logic                  pl_ready_o,
  input  logic [WORD_W-1:0]     pl_data_i,
  output logic                  tx_valid_o,
  input  logic                  tx_ready_i,
  output logic [DATA_W-1:0]     tx_data_o,
  output logic                  tx_sop_o,
  output logic                  tx_eop_o,
  output logic [EMP_W-1:0]      tx_empty_o,
  output logic [SIZE_W-1:0]     tx_size_o
);
  localparam int ACC_B = BEAT_B + WORD_B;
  localparam int CNT_W = $clog2(ACC_B + 1);
  localparam int NB_W  = $clog2(BEAT_B + 1);
  localparam int WN_W  = $clog2(WORD_B + 1);

  pf_state_e         state_q;
  logic              first_q, err_q;
  logic [SIZE_W-1:0] emit_q, pl_left_q, size_q;
  logic [NB_W-1:0]   need;
  logic [WN_W-1:0]   wr_n;
  logic [CNT_W-1:0]  acc_cnt, mid_cnt;
  logic [DATA_W-1:0] head;
  logic              cmd_take, len_ok, load, wr, pop, last, slot_free;

  assign need = (emit_q >= SIZE_W'(BEAT_B)) ? NB_W'(BEAT_B) : NB_W'(emit_q);
  assign wr_n = (pl_left_q >= SIZE_W'(WORD_B)) ? WN_W'(WORD_B) : WN_W'(pl_left_q);
  assign last = emit_q <= SIZE_W'(BEAT_B);

  assign cmd_ready_o = (state_q == PF_IDLE);
  assign cmd_take    = cmd_valid_i && cmd_ready_o;
  assign len_ok      = cmd_len_i <= SIZE_W'(MAX_PL);
  assign load        = cmd_take && len_ok;

  // pull words only until the current beat is covered
  assign pl_ready_o = (state_q == PF_BUSY) && (pl_left_q != '0) && (int'(acc_cnt) < int'(need));
  assign wr         = pl_valid_i && pl_ready_o;
  assign pop        = (state_q == PF_BUSY) && (int'(mid_cnt) >= int'(need)) && slot_free;
  assign cmd_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PF_IDLE;
      first_q   <= 1'b0;
      err_q     <= 1'b0;
      emit_q    <= '0;
      pl_left_q <= '0;
      size_q    <= '0;
    end else begin
      err_q <= cmd_take && !len_ok;
      if (load) begin
        state_q   <= PF_BUSY;
        first_q   <= 1'b1;
        emit_q    <= SIZE_W'(HDR_B) + cmd_len_i;
        pl_left_q <= cmd_len_i;
        size_q    <= SIZE_W'(HDR_B) + cmd_len_i;
      end else begin
        if (wr) pl_left_q <= pl_left_q - SIZE_W'(wr_n);
        if (pop) begin
          emit_q  <= emit_q - SIZE_W'(need);
          first_q <= 1'b0;
          if (last) state_q <= PF_IDLE;
        end
      end
    end
  end

  pf_byte_acc #(.BEAT_B(BEAT_B), .WORD_B(WORD_B), .HDR_B(HDR_B)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .hdr_i     (cmd_hdr_i),
    .wr_i      (wr),
    .wr_word_i (pl_data_i),
    .wr_n_i    (wr_n),
    .pop_i     (pop),
    .pop_n_i   (need),
    .cnt_o     (acc_cnt),
    .mid_cnt_o (mid_cnt),
    .head_o    (head)
  );

  pf_beat_out #(.BEAT_B(BEAT_B), .SIZE_W(SIZE_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (pop),
    .head_i      (head),
    .take_n_i    (need),
    .sop_i       (first_q),
    .eop_i       (last),
    .size_i      (size_q),
    .ready_i     (tx_ready_i),
    .slot_free_o (slot_free),
    .valid_o     (tx_valid_o),
    .data_o      (tx_data_o),
    .sop_o       (tx_sop_o),
    .eop_o       (tx_eop_o),
    .empty_o     (tx_empty_o),
    .size_o      (tx_size_o)
  );

  // R11: no payload is pulled while idle
  a_r11_idle_no_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !pl_ready_o);
  // R8: an error pulse follows only a refused oversize command
  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $past(cmd_valid_i && cmd_ready_o && (cmd_len_i > SIZE_W'(MAX_PL))));
  // R4: the reported size always covers at least the header
  a_r4_size_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_size_o >= SIZE_W'(HDR_B)));
endmodule

// File: tb/sim_pkt_framer.sv
`timescale 1ns/1ps
module sim_pkt_framer;
  typedef struct packed {
    logic [127:0] d;
    logic         sop;
    logic         eop;
    logic [3:0]   e;
    logic [8:0]   s;
  } beat_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [79:0]  cmd_hdr = '0;
  logic [8:0]   cmd_len = '0;
  logic         cmd_err;
  logic         pl_valid = 1'b0;
  logic         pl_ready;
  logic [31:0]  pl_data = '0;
  logic         tx_valid;
  logic         tx_ready = 1'b1;
  logic [127:0] tx_data;
  logic         tx_sop, tx_eop;
  logic [3:0]   tx_empty;
  logic [8:0]   tx_size;

  int checks = 0, fails = 0, cyc = 0;
  int ready_mode = 0, gap_mode = 0;
  int gap_seen = 0;
  bit in_pkt = 0, hold_chk = 0, mon_on = 0;
  beat_t held;
  beat_t exp_q[$];
  logic [31:0] pl_q[$];

  always #2 clk = ~clk;

  pkt_framer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_hdr_i(cmd_hdr),
    .cmd_len_i(cmd_len), .cmd_err_o(cmd_err),
    .pl_valid_i(pl_valid), .pl_ready_o(pl_ready), .pl_data_i(pl_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_sop_o(tx_sop), .tx_eop_o(tx_eop), .tx_empty_o(tx_empty), .tx_size_o(tx_size)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  // sink ready
  always @(posedge clk) begin
    #1;
    if (ready_mode == 0) tx_ready = 1'b1;
    else if (ready_mode == 1) tx_ready = ($urandom % 4) != 0;
    else tx_ready = ($urandom % 3) == 0;
  end

  // payload source: holds a word until taken
  initial begin
    bit hs;
    forever begin
      @(negedge clk);
      hs = pl_valid && pl_ready;
      @(posedge clk);
      #1;
      if (hs) void'(pl_q.pop_front());
      if (!pl_valid || hs) begin
        bit go;
        go = (gap_mode == 0) || (gap_mode == 1 && ($urandom % 3) != 0) ||
             (gap_mode == 2 && (cyc % 9) == 0);
        if (pl_q.size() != 0 && go) begin
          pl_valid = 1'b1;
          pl_data  = pl_q[0];
        end else begin
          pl_valid = 1'b0;
        end
      end
    end
  end

  // output monitor against the reference queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (hold_chk) begin
        chk(tx_valid && tx_data == held.d && tx_sop == held.sop && tx_eop == held.eop &&
            tx_empty == held.e && tx_size == held.s, "R1 stalled beat held",
            tx_data, held.d);
      end
      if (in_pkt && !tx_valid) gap_seen++;
      if (tx_valid && tx_ready) begin
        hold_chk = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected beat", tx_data, '0);
        end else begin
          beat_t x;
          x = exp_q.pop_front();
          chk(tx_data == x.d, "R2 R6 R9 beat data", tx_data, x.d);
          chk(tx_sop == x.sop && tx_eop == x.eop, "R3 sop/eop", {tx_sop, tx_eop}, {x.sop, x.eop});
          chk(tx_size == x.s, "R4 size", tx_size, x.s);
          chk(tx_empty == x.e, "R5 empty", tx_empty, x.e);
        end
        if (tx_eop) in_pkt = 0;
        else if (tx_sop) in_pkt = 1;
      end else if (tx_valid) begin
        hold_chk = 1;
        held = '{d: tx_data, sop: tx_sop, eop: tx_eop, e: tx_empty, s: tx_size};
      end else begin
        hold_chk = 0;
      end
    end
  end

  task automatic send_pkt(input int len, input logic [79:0] hdr);
    logic [7:0] b[$];
    int tot, nb;
    bit ok;
    ok  = (len <= 501);
    tot = 10 + len;
    for (int i = 0; i < 10; i++) b.push_back(hdr[79-8*i -: 8]);
    for (int j = 0; j < len; j++) b.push_back(8'(j * 7 + len + 3));
    if (ok) begin
      for (int w = 0; w < (len + 3) / 4; w++) begin
        logic [31:0] wd;
        for (int k = 0; k < 4; k++)
          wd[31-8*k -: 8] = (w * 4 + k < len) ? b[10 + w * 4 + k] : 8'hA5;
        pl_q.push_back(wd);
      end
      nb = (tot + 15) / 16;
      for (int bi = 0; bi < nb; bi++) begin
        beat_t x;
        x.d = '0;
        for (int l = 0; l < 16; l++)
          if (bi * 16 + l < tot) x.d[127-8*l -: 8] = b[bi * 16 + l];
        x.sop = (bi == 0);
        x.eop = (bi == nb - 1);
        x.e   = (bi == nb - 1) ? 4'(nb * 16 - tot) : 4'd0;
        x.s   = 9'(tot);
        exp_q.push_back(x);
      end
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b1;
    cmd_hdr   = hdr;
    cmd_len   = 9'(len);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    if (ok) begin
      chk(!cmd_ready, "R7 busy after accept", cmd_ready, 0);
      chk(!cmd_err, "R8 no error on legal length", cmd_err, 0);
    end else begin
      chk(cmd_err, "R8 error pulse", cmd_err, 1);
      chk(cmd_ready, "R8 still idle after refusal", cmd_ready, 1);
      @(negedge clk);
      chk(!cmd_err, "R8 pulse lasts one cycle", cmd_err, 0);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || pl_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !tx_valid && !pl_ready && !cmd_err, "R7 R11 reset state",
        {cmd_ready, tx_valid, pl_ready, cmd_err}, 4'b1000);
    mon_on = 1;

    // 40-byte payload: four beats, two bytes on the last
    send_pkt(40, 80'h0005DDAA4C00FEDCBA94);
    drain();

    // short and word-boundary lengths
    send_pkt(0, 80'h112233445566778899AA);
    send_pkt(6, 80'hA1A2A3A4A5A6A7A8A9AA);
    send_pkt(1, 80'h0102030405060708090A);
    send_pkt(2, 80'hF0E0D0C0B0A090807060);
    send_pkt(3, 80'h13579BDF02468ACE1234);
    send_pkt(5, 80'hDEADBEEFCAFEF00D5555);
    send_pkt(22, 80'h00FF00FF00FF00FF00FF);
    drain();

    // largest legal packet, 511 bytes
    ready_mode = 1;
    send_pkt(501, 80'h9988776655443322110F);
    drain();

    // oversize commands are refused and leave nothing behind
    ready_mode = 0;
    send_pkt(502, 80'h1);
    send_pkt(511, 80'h2);
    repeat (10) begin
      @(negedge clk);
      chk(!tx_valid && !pl_ready, "R8 R11 refused command is dropped", {tx_valid, pl_ready}, 2'b00);
    end

    // payload starvation mid-packet
    gap_mode = 2;
    gap_seen = 0;
    send_pkt(100, 80'hC0FFEE0123456789ABCD);
    drain();
    chk(gap_seen > 0, "R10 valid drops during payload stall", gap_seen, 1);

    // mixed traffic
    gap_mode = 1;
    for (int p = 0; p < 40; p++) begin
      ready_mode = p % 3;
      send_pkt(int'($urandom % 120), {$urandom, $urandom, 16'($urandom)});
    end
    drain();

    chk(exp_q.size() == 0, "R3 all expected beats seen", exp_q.size(), 0);
    finish_run();
  end
endmodule